// File: doc/BRIEF.md
# Comparator output digital filter

This block conditions the single-bit result of an analog comparator before the rest of the chip uses it. The raw bit first passes through a synchronizer. Its polarity can then be inverted. A digital filter changes its output only after a programmed number of consecutive samples all disagree with the value it currently holds.

Samples are taken on one of two timebases. The first is a tick from a programmable divider on the bus clock. The second is an external sample strobe, chosen by a mode bit. Whenever the filter is not enabled, its output simply follows the conditioned input.

A select bit routes either the unfiltered or the filtered value to the main output. Rising and falling edges on that main output set two sticky flags, which are cleared by writing one. A level interrupt is raised from each flag that has its own enable set.

Top module: `cmp_out_filter`

## Requirements
- R1: `out_unfilt` equals `cmp_raw` as it was two clock edges earlier, XOR `cfg_invert`, because the raw bit passes through a two-stage synchronizer.
- R2: With `cfg_invert`=1 the conditioned value is the complement of the synchronized raw bit; with `cfg_invert`=0 it is the same as the synchronized raw bit.
- R3: The filter is enabled only when `cfg_count` > 1 and either `cfg_ext_sample`=1 or `cfg_period` != 0. While the filter is not enabled, `out_filt` equals `out_unfilt`.
- R4: With `cfg_ext_sample`=0 and `cfg_period`=P (1 to 255), a sample is taken once every P bus-clock cycles.
- R5: With `cfg_ext_sample`=1, a sample is taken in every cycle in which `sample_strobe` is 1, and in no other cycle.
- R6: While the filter is enabled, `out_filt` takes the new value after `cfg_count` consecutive samples differ from it. A sample that agrees with `out_filt` resets the run of differing samples. Between samples, `out_filt` holds its value.
- R7: `out_sel` equals `out_filt` when `cfg_use_filt`=1, and equals `out_unfilt` when `cfg_use_filt`=0.
- R8: A 0-to-1 change of `out_sel` sets `flag_rise` one cycle later, and a 1-to-0 change sets `flag_fall` one cycle later. A flag stays set until a cycle with its clear input at 1 and no new edge of its kind. If the clear and a new edge fall in the same cycle, the flag stays set.
- R9: `irq` equals (`flag_rise` AND `ie_rise`) OR (`flag_fall` AND `ie_fall`).
- R10: During and right after reset, `out_unfilt`, `out_filt`, `out_sel`, both flags and `irq` are 0, provided `cfg_invert`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_raw | input | 1 | Raw comparator result, asynchronous to clk |
| cfg_invert | input | 1 | Invert the polarity of the comparator result |
| cfg_use_filt | input | 1 | 1 selects the filtered value for `out_sel` |
| cfg_ext_sample | input | 1 | 1 takes samples on `sample_strobe`; 0 uses the clock divider |
| cfg_count | input | 3 | Number of consecutive differing samples needed to change `out_filt` |
| cfg_period | input | 8 | Divider period in clk cycles; 0 means no divided ticks |
| sample_strobe | input | 1 | External sample pulse, synchronous to clk |
| ie_rise | input | 1 | Interrupt enable for the rising-edge flag |
| ie_fall | input | 1 | Interrupt enable for the falling-edge flag |
| clr_rise | input | 1 | Write-one-to-clear pulse for `flag_rise` |
| clr_fall | input | 1 | Write-one-to-clear pulse for `flag_fall` |
| out_unfilt | output | 1 | Synchronized result after the polarity stage |
| out_filt | output | 1 | Filtered result |
| out_sel | output | 1 | Selected output |
| flag_rise | output | 1 | Sticky rising-edge flag |
| flag_fall | output | 1 | Sticky falling-edge flag |
| irq | output | 1 | Interrupt request |

## Verification
The properties take for granted that `sample_strobe` and the clear pulses are already synchronous to `clk`. They also assume that configuration changes happen only at clock-cycle granularity, so a sample tick and the filter-enable term are well defined in every cycle. The stimulus drives every input just after the falling edge and holds it across the next rising edge. It changes the configuration only between test phases. A behavioural model in the bench tracks each phase: pass-through with and without inversion, several divider periods and counts, strobe-driven sampling, the disabling cases of count 1 and period 0, and a clear pulse held through a new edge.

// File: rtl/cof_pkg.sv
package cof_pkg;
  typedef enum logic {
    TB_DIVIDED  = 1'b0,
    TB_EXTERNAL = 1'b1
  } timebase_e;
endpackage

// File: rtl/cof_sync.sv
module cof_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cof_timebase.sv
module cof_timebase
  import cof_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  timebase_e        mode,
  input  logic [DIV_W-1:0] period,
  input  logic             strobe,
  output logic             tick
);
  logic [DIV_W-1:0] div_cnt;
  logic             div_hit;

  // Divided tick: fires when the counter reaches period-1, so one tick
  // occurs every `period` cycles; period 0 never fires.
  function automatic logic divider_hit(input logic [DIV_W-1:0] cnt,
                                       input logic [DIV_W-1:0] per);
    return (per != '0) && (cnt >= (per - DIV_W'(1)));
  endfunction

  assign div_hit = divider_hit(div_cnt, period);
  assign tick    = (mode == TB_EXTERNAL) ? strobe : div_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                     div_cnt <= '0;
    else if (mode == TB_EXTERNAL || period == '0)   div_cnt <= '0;
    else if (div_hit)                               div_cnt <= '0;
    else                                            div_cnt <= div_cnt + DIV_W'(1);
  end
endmodule

// File: rtl/cof_run_filter.sv
module cof_run_filter #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic             tick,
  input  logic             enable,
  input  logic [CNT_W-1:0] count,
  output logic             state_q,
  output logic             dout
);
  logic [CNT_W-1:0] run;
  logic             differs;
  logic             done;

  // True when this differing sample completes the required run.
  function automatic logic run_complete(input logic [CNT_W-1:0] r,
                                        input logic [CNT_W-1:0] n);
    return ({1'b0, r} + (CNT_W+1)'(1)) >= {1'b0, n};
  endfunction

  assign differs = (din != state_q);
  assign done    = run_complete(run, count);
  assign dout    = enable ? state_q : din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= 1'b0;
      run     <= '0;
    end else if (!enable) begin
      state_q <= din;
      run     <= '0;
    end else if (tick) begin
      if (!differs) begin
        run <= '0;
      end else if (done) begin
        state_q <= din;
        run     <= '0;
      end else begin
        run <= run + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/cof_edge_flags.sv
module cof_edge_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  input  logic clr_rise,
  input  logic clr_fall,
  input  logic ie_rise,
  input  logic ie_fall,
  output logic rise_evt,
  output logic fall_evt,
  output logic flag_rise,
  output logic flag_fall,
  output logic irq
);
  logic prev;

  assign rise_evt = sig & ~prev;
  assign fall_evt = ~sig & prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev      <= 1'b0;
      flag_rise <= 1'b0;
      flag_fall <= 1'b0;
    end else begin
      prev      <= sig;
      flag_rise <= (flag_rise & ~clr_rise) | rise_evt;
      flag_fall <= (flag_fall & ~clr_fall) | fall_evt;
    end
  end

  assign irq = (flag_rise & ie_rise) | (flag_fall & ie_fall);
endmodule

// File: rtl/cmp_out_filter.sv
module cmp_out_filter
  import cof_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 3,
  parameter int DIV_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_raw,
  input  logic             cfg_invert,
  input  logic             cfg_use_filt,
  input  logic             cfg_ext_sample,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic [DIV_W-1:0] cfg_period,
  input  logic             sample_strobe,
  input  logic             ie_rise,
  input  logic             ie_fall,
  input  logic             clr_rise,
  input  logic             clr_fall,
  output logic             out_unfilt,
  output logic             out_filt,
  output logic             out_sel,
  output logic             flag_rise,
  output logic             flag_fall,
  output logic             irq
);
  logic      sync_q;
  logic      tick;
  logic      filter_on;
  logic      filt_q;
  logic      rise_evt;
  logic      fall_evt;
  timebase_e tb_mode;

  function automatic logic filter_enabled(input logic [CNT_W-1:0] n,
                                          input logic [DIV_W-1:0] per,
                                          input logic             ext);
    return (n > CNT_W'(1)) && (ext || (per != '0));
  endfunction

  assign tb_mode   = cfg_ext_sample ? TB_EXTERNAL : TB_DIVIDED;
  assign filter_on = filter_enabled(cfg_count, cfg_period, cfg_ext_sample);

  cof_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(cmp_raw), .q(sync_q)
  );

  assign out_unfilt = sync_q ^ cfg_invert;

  cof_timebase #(.DIV_W(DIV_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .mode(tb_mode), .period(cfg_period),
    .strobe(sample_strobe), .tick(tick)
  );

  cof_run_filter #(.CNT_W(CNT_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .din(out_unfilt), .tick(tick),
    .enable(filter_on), .count(cfg_count), .state_q(filt_q), .dout(out_filt)
  );

  assign out_sel = cfg_use_filt ? out_filt : out_unfilt;

  cof_edge_flags u_flags (
    .clk(clk), .rst_n(rst_n), .sig(out_sel),
    .clr_rise(clr_rise), .clr_fall(clr_fall),
    .ie_rise(ie_rise), .ie_fall(ie_fall),
    .rise_evt(rise_evt), .fall_evt(fall_evt),
    .flag_rise(flag_rise), .flag_fall(flag_fall), .irq(irq)
  );
endmodule

// File: rtl/cmp_out_filter_chk.sv
module cmp_out_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic filter_on,
  input logic filt_q,
  input logic out_unfilt,
  input logic out_filt,
  input logic rise_evt,
  input logic fall_evt,
  input logic clr_rise,
  input logic clr_fall,
  input logic flag_rise,
  input logic flag_fall,
  input logic ie_rise,
  input logic ie_fall,
  input logic irq
);
  AST_BYPASS_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !filter_on |-> (out_filt == out_unfilt)); // R3

  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (filter_on && !tick) |=> $stable(filt_q)); // R6

  AST_CHANGE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(filter_on) && !$stable(filt_q)) |-> $past(tick)); // R6

  AST_RISE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> flag_rise); // R8

  AST_FALL_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> flag_fall); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rise && !clr_rise) |=> flag_rise); // R8

  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_fall && clr_fall && !fall_evt) |=> !flag_fall); // R8

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_rise && !ie_fall) |-> !irq); // R9
endmodule

bind cmp_out_filter cmp_out_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .filter_on(filter_on),
  .filt_q(filt_q), .out_unfilt(out_unfilt), .out_filt(out_filt),
  .rise_evt(rise_evt), .fall_evt(fall_evt),
  .clr_rise(clr_rise), .clr_fall(clr_fall),
  .flag_rise(flag_rise), .flag_fall(flag_fall),
  .ie_rise(ie_rise), .ie_fall(ie_fall), .irq(irq)
);

// File: tb/cmp_out_filter_tb.sv
module cmp_out_filter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_raw = 0, cfg_invert = 0, cfg_use_filt = 0, cfg_ext_sample = 0;
  logic [2:0] cfg_count = 0;
  logic [7:0] cfg_period = 0;
  logic sample_strobe = 0, ie_rise = 0, ie_fall = 0, clr_rise = 0, clr_fall = 0;
  logic out_unfilt, out_filt, out_sel, flag_rise, flag_fall, irq;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;
  bit done    = 0;
  string phase = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_out_filter u_dut (
    .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .cfg_invert(cfg_invert),
    .cfg_use_filt(cfg_use_filt), .cfg_ext_sample(cfg_ext_sample),
    .cfg_count(cfg_count), .cfg_period(cfg_period),
    .sample_strobe(sample_strobe), .ie_rise(ie_rise), .ie_fall(ie_fall),
    .clr_rise(clr_rise), .clr_fall(clr_fall),
    .out_unfilt(out_unfilt), .out_filt(out_filt), .out_sel(out_sel),
    .flag_rise(flag_rise), .flag_fall(flag_fall), .irq(irq)
  );

  // Behavioural reference model
  bit sync_q[$];
  int div_pos, run_len;
  bit held, last_sel, m_fr, m_ff;

  function automatic bit m_unf();
    return sync_q[1] ^ cfg_invert;
  endfunction
  function automatic bit m_on();
    return (int'(cfg_count) >= 2) && (cfg_ext_sample || cfg_period != 0);
  endfunction
  function automatic bit m_filt();
    return m_on() ? held : m_unf();
  endfunction
  function automatic bit m_sel();
    return cfg_use_filt ? m_filt() : m_unf();
  endfunction

  task automatic model_reset();
    sync_q = '{0, 0};
    div_pos = 0; run_len = 0;
    held = 0; last_sel = 0; m_fr = 0; m_ff = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      bit sample_now, v, s;
      int per;
      per = int'(cfg_period);
      if (cfg_ext_sample) sample_now = sample_strobe;
      else sample_now = (per > 0) && (div_pos == per - 1 || div_pos >= per);
      v = m_unf();
      s = m_sel();
      if (!m_on()) begin held = v; run_len = 0; end
      else if (sample_now) begin
        if (v == held) run_len = 0;
        else if (run_len + 1 >= int'(cfg_count)) begin held = v; run_len = 0; end
        else run_len++;
      end
      if (cfg_ext_sample || per == 0 || sample_now) div_pos = 0;
      else div_pos++;
      m_fr = (m_fr && !clr_rise) || (s && !last_sel);
      m_ff = (m_ff && !clr_fall) || (!s && last_sel);
      last_sel = s;
      void'(sync_q.pop_back());
      sync_q.push_front(cmp_raw);
    end
  end

  task automatic cmp1(string req, string what, bit act, bit exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0b expected=%0b (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit ir;
    ir = (m_fr && ie_rise) || (m_ff && ie_fall);
    cmp1((cfg_invert ? "R2" : "R1"), "out_unfilt", out_unfilt, m_unf());
    cmp1(phase, "out_filt", out_filt, m_filt());
    cmp1("R7", "out_sel", out_sel, m_sel());
    cmp1("R8", "flag_rise", flag_rise, m_fr);
    cmp1("R8", "flag_fall", flag_fall, m_ff);
    cmp1("R9", "irq", irq, ir);
  endtask

  task automatic run(int n);
    repeat (n) begin
      @(negedge clk);
      #1 compare_all();
    end
  endtask

  task automatic drive_pattern(int seed, int len, int hold_max);
    int x;
    x = seed;
    for (int i = 0; i < len; i++) begin
      x = (x * 1103515245 + 12345) & 32'h7fffffff;
      cmp_raw = x[16];
      run(1 + (x[20:17] % hold_max));
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    run(3);
    rst_n = 1'b1;
    run(2);

    // R1 / R2: pass-through, both polarities, flags and irq enabled
    phase = "R3";
    ie_rise = 1; ie_fall = 1;
    drive_pattern(7, 40, 4);
    cfg_invert = 1;
    drive_pattern(11, 40, 4);
    cfg_invert = 0;
    clr_rise = 1; clr_fall = 1; run(1); clr_rise = 0; clr_fall = 0; run(2);

    // R4 / R6: divided timebase, period 3, count 4, filtered output selected
    phase = "R4";
    cfg_use_filt = 1; cfg_count = 4; cfg_period = 3;
    drive_pattern(23, 60, 15);
    cmp_raw = ~cmp_raw; run(40);
    // R6: glitch shorter than the run, then long level
    cmp_raw = ~cmp_raw; run(5); cmp_raw = ~cmp_raw; run(30);

    // R4: period 1 and period 255, count 7
    phase = "R6";
    cfg_period = 1; cfg_count = 7;
    drive_pattern(31, 60, 10);
    cfg_period = 255; cfg_count = 2;
    cmp_raw = ~cmp_raw; run(600);

    // R3: count 1 and period 0 disable filtering
    phase = "R3";
    cfg_count = 1; cfg_period = 5;
    drive_pattern(41, 30, 3);
    cfg_count = 5; cfg_period = 0;
    drive_pattern(43, 30, 3);

    // R5: external strobe, every other cycle then sparse
    phase = "R5";
    cfg_ext_sample = 1; cfg_count = 3;
    for (int i = 0; i < 120; i++) begin
      if (i % 9 == 0) cmp_raw = ~cmp_raw;
      sample_strobe = (i % 2 == 0);
      run(1);
    end
    for (int i = 0; i < 120; i++) begin
      if (i % 13 == 0) cmp_raw = ~cmp_raw;
      sample_strobe = (i % 5 == 0);
      run(1);
    end
    sample_strobe = 0;
    cmp_raw = ~cmp_raw; run(20);   // no strobes: filter must hold

    // R8: clear held through a new edge keeps the flag; R9 enable masking
    phase = "R8";
    cfg_ext_sample = 0; cfg_use_filt = 0; cfg_count = 0;
    ie_rise = 0; ie_fall = 1;
    clr_rise = 1;
    for (int i = 0; i < 8; i++) begin cmp_raw = ~cmp_raw; run(3); end
    clr_rise = 0;
    ie_rise = 1; ie_fall = 0;
    run(4);
    clr_fall = 1; run(1); clr_fall = 0;
    clr_rise = 1; run(1); clr_rise = 0;
    run(4);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule